// File: doc/BRIEF.md
# Spatial Random-Dither Bit Reducer

This block takes a stream of 12-bit-per-channel pixels (RGB or YCbCr, handled alike) and lowers them to 6, 8 or 10 significant bits per channel. Before the low bits are dropped, a small pseudo-random offset is added to each channel. The offsets come from three 28-bit linear feedback shift registers, one per channel. This spreads the quantisation error over space, so flat gradients show noise in place of bands.

The input is a stream qualified by a valid strobe, with start-of-frame and start-of-line markers. The configuration inputs select the depth, turn dithering on, supply one seed per channel, choose a shared polynomial or a separate polynomial per channel, pick whether the generators reload at every frame, and enable a high-pass shaping of the noise. A small frame index, active only in the per-frame reload mode, is mixed into the noise so that successive frames differ. Results appear one clock later with their markers aligned. Each result stays 12 bits wide and MSB-aligned, and its dropped bits read as zero.

Top module: `rand_dither_reducer`

## Requirements
- R1: The depth code `cfg_depth` keeps 6 bits per channel at 0, 8 at 1 and 10 at 2 (code 3 behaves as 2). Output words are 12 bits with the kept bits at the top and the dropped W low bits (W = 6, 4, 2) forced to zero.
- R2: With `cfg_en` low, each output channel equals its input with the W low bits cleared, and no noise is added.
- R3: Each generator steps as next = {s[26:0], s[27] ^ s[k-1]}. With `cfg_split_poly` low, k = 3 for all channels. With it high, k = 3 for R, 9 for G and 13 for B.
- R4: The value a generator presents for a pixel is its own seed input when `cfg_en` was low on the previous cycle (or since reset), or, with `cfg_frame_reseed` high, on a valid start-of-frame pixel. Otherwise it is the stored state. The state steps once per valid pixel and never on idle cycles.
- R5: The raw noise of a channel is the low W bits of its presented value XOR the current frame index.
- R6: With `cfg_en` and `cfg_frame_reseed` high, the frame index advances on every valid start-of-frame pixel and applies to that pixel. It wraps to 0 after 15 for depth codes 0 and 1, and after 3 for codes 2 and 3. Otherwise it is held at 0.
- R7: With `cfg_hpf` high, the added noise is (raw + 2^W - prev) / 2, rounded down. Here prev is the raw noise of the previous valid pixel, taken as 0 on a pixel that loads the seed.
- R8: The sum of pixel and noise saturates at 4095 before truncation, so a full-scale input never wraps.
- R9: `out_valid`, `out_sof` and `out_sol` follow `in_valid`, `in_valid & in_sof` and `in_valid & in_sol` one cycle later. Output data updates only on valid input and holds otherwise. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_r | input | 12 | Channel 0 (R or Cr) |
| in_g | input | 12 | Channel 1 (G or Y) |
| in_b | input | 12 | Channel 2 (B or Cb) |
| cfg_en | input | 1 | Dither enable |
| cfg_depth | input | 2 | Output depth code |
| cfg_seed_r | input | 28 | Seed for channel 0 generator |
| cfg_seed_g | input | 28 | Seed for channel 1 generator |
| cfg_seed_b | input | 28 | Seed for channel 2 generator |
| cfg_split_poly | input | 1 | Separate polynomial per channel |
| cfg_frame_reseed | input | 1 | Reload seeds each frame, run frame index |
| cfg_hpf | input | 1 | High-pass noise shaping |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | Frame start, aligned with output data |
| out_sol | output | 1 | Line start, aligned with output data |
| out_r | output | 12 | Reduced channel 0 |
| out_g | output | 12 | Reduced channel 1 |
| out_b | output | 12 | Reduced channel 2 |

## Verification
The assertions check on every cycle the properties that need no noise model: the one-cycle alignment of valid and markers, data hold on idle cycles, zeroed low bits at 6-bit depth, plain truncation with dithering off, and the absence of wrap-around at full scale. The exact noise values depend on the generator sequence, the seed reload points, the frame index wrap and the high-pass history. Only the bench scenarios can show these, by comparing every output against an arithmetic model over a sweep of all depth, polynomial, reload and filter settings, plus long runs that carry the frame index through its wrap at both limits.

// File: rtl/dith_pkg.sv
// Shared constants and helpers for the spatial dither bit reducer.
// Assumes 3 colour channels and a depth code of 2 bits.
package dith_pkg;
    localparam int NUM_CH    = 3;
    localparam int DEPTH_W   = 2;
    localparam int TAP_BASE  = 3;

    // Feedback tap used by a channel in per-channel polynomial mode.
    function automatic int split_tap(input int ch);
        return (ch == 0) ? 3 : (ch == 1) ? 9 : 13;
    endfunction
endpackage

// File: rtl/dith_frame_ctr.sv
// Frame index for per-frame reseeding. Advances on each valid frame
// start while dither and per-frame reload are on, wrapping at a limit
// chosen by the depth code. idx_cur is the value that applies to the
// current input pixel (already advanced on a frame start).
module dith_frame_ctr #(
    parameter int FRAME_W = 4,
    parameter int DEPTH_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               reseed,
    input  logic [DEPTH_W-1:0] depth,
    input  logic               fire,
    input  logic               sof,
    output logic [FRAME_W-1:0] idx_cur
);
    localparam logic [FRAME_W-1:0] LIM_WIDE   = {FRAME_W{1'b1}};
    localparam logic [FRAME_W-1:0] LIM_NARROW = FRAME_W'(3);

    logic [FRAME_W-1:0] idx_q;
    logic [FRAME_W-1:0] lim;

    // Pick the wrap limit from the depth code.
    always_comb lim = (depth >= DEPTH_W'(2)) ? LIM_NARROW : LIM_WIDE;

    // Compute the index valid for this cycle's pixel.
    always_comb begin
        if (!en || !reseed)
            idx_cur = '0;
        else if (fire && sof)
            idx_cur = (idx_q >= lim) ? '0 : idx_q + FRAME_W'(1);
        else
            idx_cur = idx_q;
    end

    // Keep the index between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_cur;
    end
endmodule

// File: rtl/dith_noise_gen.sv
// One channel's noise source: a 28-bit Fibonacci LFSR with a selectable
// second tap, mixed with the frame index, masked to the dropped-bit
// width and optionally high-pass shaped against the previous sample.
// Assumes drop <= NOISE_W and FRAME_W <= NOISE_W.
module dith_noise_gen #(
    parameter int LFSR_W    = 28,
    parameter int NOISE_W   = 6,
    parameter int FRAME_W   = 4,
    parameter int DROP_W    = 3,
    parameter int TAP_COMMON = 3,
    parameter int TAP_SPLIT  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               split,
    input  logic [LFSR_W-1:0]  seed,
    input  logic               reload,
    input  logic               fire,
    input  logic               hpf,
    input  logic [FRAME_W-1:0] frame_idx,
    input  logic [DROP_W-1:0]  drop,
    output logic [NOISE_W-1:0] noise
);
    localparam int SUM_W = NOISE_W + 2;

    logic [LFSR_W-1:0]  state_q, cur, nxt;
    logic [NOISE_W-1:0] prev_q, prev_eff, raw, low_mask;
    logic [SUM_W-1:0]   hp_sum;
    logic               fb;

    // Value presented for this pixel: seed on a load, else stored state.
    always_comb cur = reload ? seed : state_q;

    // Feedback from the top bit and the selected second tap.
    always_comb fb = cur[LFSR_W-1] ^ (split ? cur[TAP_SPLIT-1] : cur[TAP_COMMON-1]);
    always_comb nxt = {cur[LFSR_W-2:0], fb};

    // Raw noise: low bits XOR frame index, limited to the dropped width.
    always_comb begin
        low_mask = ~({NOISE_W{1'b1}} << drop);
        raw      = (cur[NOISE_W-1:0] ^ NOISE_W'(frame_idx)) & low_mask;
        prev_eff = reload ? '0 : prev_q;
    end

    // High-pass: halved difference, offset by one full range.
    always_comb begin
        hp_sum = SUM_W'(raw) + (SUM_W'(1) << drop) - SUM_W'(prev_eff);
        noise  = hpf ? NOISE_W'(hp_sum >> 1) : raw;
    end

    // Step on each accepted pixel; park on the seed for an idle load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            prev_q  <= '0;
        end else if (fire) begin
            state_q <= nxt;
            prev_q  <= raw;
        end else if (reload) begin
            state_q <= seed;
            prev_q  <= '0;
        end
    end
endmodule

// File: rtl/dith_quant.sv
// Adds noise to one channel, saturates at full scale and clears the
// dropped low bits. With en low the noise is ignored.
module dith_quant #(
    parameter int PIX_W   = 12,
    parameter int NOISE_W = 6
) (
    input  logic               en,
    input  logic [PIX_W-1:0]   pix,
    input  logic [NOISE_W-1:0] noise,
    input  logic [PIX_W-1:0]   keep_mask,
    output logic [PIX_W-1:0]   q
);
    logic [PIX_W:0]   sum;
    logic [PIX_W-1:0] sat;

    // Add, clip at the channel maximum, then truncate.
    always_comb begin
        sum = {1'b0, pix} + (PIX_W+1)'(noise);
        if (!en)          sat = pix;
        else if (sum[PIX_W]) sat = {PIX_W{1'b1}};
        else              sat = sum[PIX_W-1:0];
        q = sat & keep_mask;
    end
endmodule

// File: rtl/rand_dither_reducer.sv
// Spatial random-dither bit reducer, top level. Three noise generators
// (one per channel), a shared frame index and one output register stage.
// Assumes PIX_W >= 10 so that all depth codes are meaningful.
module rand_dither_reducer
    import dith_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int LFSR_W  = 28,
    parameter int FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_sol,
    input  logic [PIX_W-1:0]   in_r,
    input  logic [PIX_W-1:0]   in_g,
    input  logic [PIX_W-1:0]   in_b,
    input  logic               cfg_en,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [LFSR_W-1:0]  cfg_seed_r,
    input  logic [LFSR_W-1:0]  cfg_seed_g,
    input  logic [LFSR_W-1:0]  cfg_seed_b,
    input  logic               cfg_split_poly,
    input  logic               cfg_frame_reseed,
    input  logic               cfg_hpf,
    output logic               out_valid,
    output logic               out_sof,
    output logic               out_sol,
    output logic [PIX_W-1:0]   out_r,
    output logic [PIX_W-1:0]   out_g,
    output logic [PIX_W-1:0]   out_b
);
    localparam int NOISE_W = PIX_W - 6;
    localparam int DROP_W  = $clog2(NOISE_W + 1);

    logic                loaded_q;
    logic                reload;
    logic [FRAME_W-1:0]  frame_idx;
    logic [DROP_W-1:0]   drop;
    logic [PIX_W-1:0]    keep_mask;
    logic [PIX_W-1:0]    pix_in  [NUM_CH];
    logic [PIX_W-1:0]    pix_out [NUM_CH];
    logic [LFSR_W-1:0]   seeds   [NUM_CH];
    logic [PIX_W-1:0]    out_q   [NUM_CH];

    // Gather channel inputs into arrays for the generate loop.
    always_comb begin
        pix_in[0] = in_r;  pix_in[1] = in_g;  pix_in[2] = in_b;
        seeds[0]  = cfg_seed_r; seeds[1] = cfg_seed_g; seeds[2] = cfg_seed_b;
    end

    // Dropped-bit count and mask of the kept bits.
    always_comb begin
        case (cfg_depth)
            2'd0:    drop = DROP_W'(NOISE_W);
            2'd1:    drop = DROP_W'(NOISE_W - 2);
            default: drop = DROP_W'(NOISE_W - 4);
        endcase
        keep_mask = {PIX_W{1'b1}} << drop;
    end

    // Seed load on first enabled cycle or on a reseeding frame start.
    always_comb reload = cfg_en & (~loaded_q | (cfg_frame_reseed & in_valid & in_sof));

    // Remember whether dither was on last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) loaded_q <= 1'b0;
        else        loaded_q <= cfg_en;
    end

    dith_frame_ctr #(.FRAME_W(FRAME_W), .DEPTH_W(DEPTH_W)) frame_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_en),
        .reseed  (cfg_frame_reseed),
        .depth   (cfg_depth),
        .fire    (in_valid),
        .sof     (in_sof),
        .idx_cur (frame_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NOISE_W-1:0] noise;

        dith_noise_gen #(
            .LFSR_W     (LFSR_W),
            .NOISE_W    (NOISE_W),
            .FRAME_W    (FRAME_W),
            .DROP_W     (DROP_W),
            .TAP_COMMON (TAP_BASE),
            .TAP_SPLIT  (split_tap(c))
        ) gen_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .split     (cfg_split_poly),
            .seed      (seeds[c]),
            .reload    (reload),
            .fire      (in_valid),
            .hpf       (cfg_hpf),
            .frame_idx (frame_idx),
            .drop      (drop),
            .noise     (noise)
        );

        dith_quant #(.PIX_W(PIX_W), .NOISE_W(NOISE_W)) quant_i (
            .en        (cfg_en),
            .pix       (pix_in[c]),
            .noise     (noise),
            .keep_mask (keep_mask),
            .q         (pix_out[c])
        );

        // Register the channel result on each accepted pixel.
        always_ff @(posedge clk) begin
            if (!rst_n)        out_q[c] <= '0;
            else if (in_valid) out_q[c] <= pix_out[c];
        end
    end

    // Register the qualifier and markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid & in_sof;
            out_sol   <= in_valid & in_sol;
        end
    end

    // Drive the data ports from the channel registers.
    always_comb begin
        out_r = out_q[0];
        out_g = out_q[1];
        out_b = out_q[2];
    end
endmodule

// File: rtl/rand_dither_reducer_chk.sv
// Cycle-level properties of the dither reducer's port behaviour.
module rand_dither_reducer_chk #(
    parameter int PIX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic [PIX_W-1:0] in_r,
    input logic             cfg_en,
    input logic [1:0]       cfg_depth,
    input logic             out_valid,
    input logic             out_sof,
    input logic [PIX_W-1:0] out_r,
    input logic [PIX_W-1:0] out_g,
    input logic [PIX_W-1:0] out_b
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_SOF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> out_sof); // R9
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R9
    AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_depth == 2'd0) |=>
        (out_r[PIX_W-7:0] == '0 && out_g[PIX_W-7:0] == '0 && out_b[PIX_W-7:0] == '0)); // R1
    AST_PLAIN_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_en && cfg_depth == 2'd2) |=>
        (out_r[PIX_W-1:2] == $past(in_r[PIX_W-1:2]))); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_r == {PIX_W{1'b1}}) |=> (out_r[PIX_W-1 -: 2] == 2'b11)); // R8
endmodule

bind rand_dither_reducer rand_dither_reducer_chk #(.PIX_W(PIX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_r      (in_r),
    .cfg_en    (cfg_en),
    .cfg_depth (cfg_depth),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
);

// File: tb/rand_dither_reducer_tb_top.sv
// Sweep bench: every depth/enable/polynomial/reload/filter setting over
// short frames, plus long runs through both frame-index wraps. Expected
// outputs come from an arithmetic model of the requirements.
module rand_dither_reducer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [11:0] in_r = '0, in_g = '0, in_b = '0;
    logic        c_en = 1'b0;
    logic [1:0]  c_depth = '0;
    logic [27:0] c_seed [3];
    logic        c_split = 1'b0, c_reseed = 1'b0, c_hpf = 1'b0;
    logic        out_valid, out_sof, out_sol;
    logic [11:0] out_r, out_g, out_b;

    int n_checks = 0;
    int n_bad    = 0;

    // model state
    logic [27:0] m_lfsr [3];
    int          m_prev [3];
    bit          m_loaded = 0;
    int          m_cnt = 0;
    bit          e_valid = 0, e_sof = 0, e_sol = 0;
    int          e_pix [3] = '{0, 0, 0};
    string       e_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    rand_dither_reducer dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .cfg_en(c_en), .cfg_depth(c_depth),
        .cfg_seed_r(c_seed[0]), .cfg_seed_g(c_seed[1]), .cfg_seed_b(c_seed[2]),
        .cfg_split_poly(c_split), .cfg_frame_reseed(c_reseed), .cfg_hpf(c_hpf),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic logic [27:0] lstep(input logic [27:0] s, input int tap);
        return {s[26:0], s[27] ^ s[tap-1]};
    endfunction

    // Model one cycle from the requirements (R1..R9).
    task automatic model(input bit v, input bit s, input bit l, input int px [3]);
        int  w, lim, cnt_cur;
        bit  reload;
        w      = (c_depth == 0) ? 6 : (c_depth == 1) ? 4 : 2;      // R1
        lim    = (c_depth <= 1) ? 15 : 3;                          // R6
        reload = c_en && (!m_loaded || (c_reseed && v && s));      // R4
        if (!c_en || !c_reseed) cnt_cur = 0;
        else if (v && s)        cnt_cur = (m_cnt >= lim) ? 0 : m_cnt + 1;
        else                    cnt_cur = m_cnt;
        for (int ch = 0; ch < 3; ch++) begin
            int tap, prev, raw, n, o;
            logic [27:0] cur;
            tap  = !c_split ? 3 : (ch == 0) ? 3 : (ch == 1) ? 9 : 13; // R3
            cur  = reload ? c_seed[ch] : m_lfsr[ch];
            prev = reload ? 0 : m_prev[ch];
            raw  = (int'(cur[5:0]) ^ cnt_cur) & ((1 << w) - 1);     // R5
            n    = c_hpf ? (raw + (1 << w) - prev) / 2 : raw;      // R7
            o    = c_en ? px[ch] + n : px[ch];                     // R2
            if (o > 4095) o = 4095;                                // R8
            o    = (o >> w) << w;
            if (v) begin
                e_pix[ch]  = o;
                m_lfsr[ch] = lstep(cur, tap);
                m_prev[ch] = raw;
            end else if (reload) begin
                m_lfsr[ch] = cur;
                m_prev[ch] = 0;
            end
        end
        m_cnt    = cnt_cur;
        m_loaded = c_en;
        e_valid  = v;
        e_sof    = v && s;
        e_sol    = v && l;
        if (!v)            e_tag = "R9 hold";
        else if (!c_en)    e_tag = "R2 truncate";
        else if (reload)   e_tag = "R4 seed load";
        else if (c_hpf)    e_tag = "R7 highpass";
        else if (c_reseed) e_tag = "R6 frame index";
        else if (px[0] > 4090) e_tag = "R8 saturate";
        else               e_tag = "R3/R5 noise";
    endtask

    task automatic compare();
        n_checks++;
        if (out_valid !== e_valid || out_sof !== e_sof || out_sol !== e_sol) begin
            n_bad++;
            $display("FAIL R9 markers: got v%0b f%0b l%0b exp v%0b f%0b l%0b",
                     out_valid, out_sof, out_sol, e_valid, e_sof, e_sol);
        end
        n_checks++;
        if (int'(out_r) != e_pix[0] || int'(out_g) != e_pix[1] || int'(out_b) != e_pix[2]) begin
            n_bad++;
            $display("FAIL %s (R1 depth %0d): got %0d %0d %0d exp %0d %0d %0d",
                     e_tag, c_depth, out_r, out_g, out_b, e_pix[0], e_pix[1], e_pix[2]);
        end
    endtask

    // Drive one cycle, step the model, then check at the next falling edge.
    task automatic tick(input bit v, input bit s, input bit l, input int r, input int g, input int b);
        int px [3];
        px = '{r, g, b};
        in_valid = v; in_sof = s; in_sol = l;
        in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
        model(v, s, l, px);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        c_seed = '{28'h0A5F3C1, 28'h5B2E7D4, 28'hC3D9E82};
        for (int ch = 0; ch < 3; ch++) begin m_lfsr[ch] = '0; m_prev[ch] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare();  // R9 reset state: all outputs zero

        // Sweep every configuration.
        for (int cfg = 0; cfg < 64; cfg++) begin
            c_en = 1'b0;
            tick(0, 0, 0, 0, 0, 0);
            c_depth  = 2'(cfg & 3);
            c_en     = cfg[2];
            c_split  = cfg[3];
            c_reseed = cfg[4];
            c_hpf    = cfg[5];
            c_seed   = '{28'(32'h0A5F3C1 + cfg * 977), 28'(32'h5B2E7D4 ^ (cfg * 31)),
                         28'(32'hC3D9E82 + cfg * 12345)};
            for (int f = 0; f < 3; f++)
                for (int ln = 0; ln < 2; ln++)
                    for (int p = 0; p < 5; p++) begin
                        int r, g, b;
                        r = (f * 977 + ln * 311 + p * 1234 + cfg * 53) % 4096;
                        if (p == 4) r = 4095;
                        g = 4095 - r;
                        b = (p == 3) ? 4094 : (r * 7) % 4096;
                        tick(1, (ln == 0 && p == 0), (p == 0), r, g, b);
                        if (p == 1) tick(0, 0, 0, 0, 0, 0);
                    end
        end

        // R6: frame index wrap at 15 (depth 1) and at 3 (depth 2).
        for (int d = 1; d <= 2; d++) begin
            c_en = 1'b0;
            tick(0, 0, 0, 0, 0, 0);
            c_en = 1'b1; c_reseed = 1'b1; c_hpf = 1'b0; c_split = 1'b1;
            c_depth = 2'(d);
            c_seed = '{28'h0000000, 28'h0000000, 28'h0000001};
            for (int f = 0; f < 20; f++) begin
                tick(1, 1, 1, 1000 + f, 2000, 3000);
                tick(1, 0, 0, 1000, 2000 + f, 4095);
            end
        end

        // R8: full-scale input with maximum noise at every depth.
        for (int d = 0; d < 3; d++) begin
            c_en = 1'b0;
            tick(0, 0, 0, 0, 0, 0);
            c_en = 1'b1; c_reseed = 1'b0; c_hpf = 1'b0;
            c_depth = 2'(d);
            c_seed = '{28'hFFFFFFF, 28'h000003F, 28'h7FFFFFF};
            for (int p = 0; p < 6; p++) tick(1, p == 0, p == 0, 4095, 4090, 4095);
        end

        finish_run();
    end
endmodule